// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end that lets a host microcontroller read and write the register map of a multi-channel data converter over SPI. The design oversamples the host's serial clock, chip select and data pins in the chip's own clock domain. Every frame opens with an 8-bit control byte, and after it come 24-bit data words. The control byte names a device, a starting register and a direction. On the other side the block drives a plain synchronous parallel port into a register file: a read address, read data that returns one clock later, and a single-cycle write strobe with its address and data.

Reads and writes advance the register address in different ways. A read starts at the addressed register. A 2-bit setting from outside then moves the address on after each word: it can hold the address, loop it inside a pair of registers, loop it inside a block of six, or walk the whole map. A write advances one address per word and wraps at the end of the map. Two parameter masks set which addresses exist and which of them can be written. The serial data output is split into a data bit and an output enable, for a pad tristate buffer.

The host's SCK half-period must be at least 4 cycles of `clk`.

Top module: `spi_regmap_slave`

## Requirements
- R1: SDI is captured on each rising SCK edge and SDO changes only after falling SCK edges. This holds whether SCK idles low or high between frames (SPI modes 0,0 and 1,1). All fields are sent most significant bit first.
- R2: A frame starts when CS_n goes low and ends when it goes high. A frame cut short leaves nothing behind: the next frame decodes a fresh control byte.
- R3: While CS_n is high, sdo_oe is 0, and toggling SCK or SDI causes no register write and no output.
- R4: The first 8 bits of a frame form the control byte. Bits 7:6 are the device select, bits 5:1 are the start register address and bit 0 is the direction (1 = read, 0 = write). Each later data word is 24 bits.
- R5: The frame is acted on only if the device select equals DEV_ID (default 2'b01). On any other value, sdo_oe stays 0 and no write happens until CS_n rises.
- R6: In a read, the first word comes from the start address. Each later word uses the next address, chosen by rd_mode: 2'b00 keeps the same address; 2'b01 toggles address bit 0; 2'b10 steps upward inside the aligned block of six (blocks start at multiples of 6) and returns to the block start past its end or past address 31; 2'b11 steps upward and wraps from 31 to 0.
- R7: A read word from an address with a 0 in DEF_MASK is all zeros. When the start address itself is undefined, every word of that frame is zero.
- R8: In a write, each complete word goes to the current address and the address then steps by one, wrapping from 31 to 0. The word is only committed (reg_we for one cycle) if the address is set in WR_MASK. A word sent to a defined read-only address is discarded, but the address still advances.
- R9: A write word sent to an undefined address is discarded and the address does not advance.
- R10: sdo_oe stays 0 for the whole of a write frame and during the control byte of every frame.
- R11: After reset, sdo_oe and reg_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI data from the host |
| sdo_o | output | 1 | SPI data to the host (valid while sdo_oe is 1) |
| sdo_oe | output | 1 | Output enable for the SDO pad buffer; 0 means high impedance |
| rd_mode | input | 2 | Read address stepping setting |
| reg_raddr | output | 5 | Register file read address |
| reg_rdata | input | 24 | Register file read data, valid one clock after reg_raddr |
| reg_we | output | 1 | Register file write strobe, one cycle per committed word |
| reg_waddr | output | 5 | Register file write address |
| reg_wdata | output | 24 | Register file write data |

## Verification
The bench builds the block with DEF_MASK = 32'hBFFF_EFFF and WR_MASK = 32'h8000_FF01. This leaves address 12 undefined but writable, and address 30 undefined. The writable set is 0, 8–15 and 31, so address 16 is defined but read-only. With these masks the bench can reach the zeroed reads, the stalled write address on an undefined register, the discarded read-only write, and the write wrap from 31 to 0. With the group sizes left at 2 and 6, a read starting at 28 in rd_mode 2'b10 returns to 24, and a read starting at 4 returns to 0. The SCK half-period is 8 clocks, and frames are run with SCK idling both low and high.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_READ,
    PH_WRITE,
    PH_SKIP
  } phase_e;

  localparam logic       DIR_READ = 1'b1;
  localparam logic [1:0] RM_HOLD  = 2'b00;
  localparam logic [1:0] RM_PAIR  = 2'b01;
  localparam logic [1:0] RM_SIX   = 2'b10;
  localparam logic [1:0] RM_ALL   = 2'b11;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_q, cs_q, sdi_q;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck};
      cs_q  <= {cs_q[STAGES-2:0], cs_n};
      sdi_q <= {sdi_q[STAGES-2:0], sdi};
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign cs_idle  = cs_q[STAGES-1];
  assign sdi_s    = sdi_q[STAGES-1];
endmodule

// File: rtl/spi_rd_stepper.sv
module spi_rd_stepper #(
  parameter int ADDR_W = 5,
  parameter int GRP_A  = 2,
  parameter int GRP_B  = 6
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] nxt
);
  import spi_regmap_pkg::*;
  localparam int MAP = 1 << ADDR_W;

  function automatic logic [ADDR_W-1:0] loop_in(input logic [ADDR_W-1:0] a, input int size);
    int base, nx;
    base = (int'(a) / size) * size;
    nx   = int'(a) + 1;
    if (nx >= base + size || nx >= MAP) nx = base;
    return ADDR_W'(nx);
  endfunction

  always_comb begin
    case (mode)
      RM_HOLD: nxt = cur;
      RM_PAIR: nxt = loop_in(cur, GRP_A);
      RM_SIX:  nxt = loop_in(cur, GRP_B);
      default: nxt = cur + ADDR_W'(1);
    endcase
  end
endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave #(
  parameter int                      DATA_W      = 24,
  parameter int                      ADDR_W      = 5,
  parameter int                      DEV_W       = 2,
  parameter logic [DEV_W-1:0]        DEV_ID      = 2'b01,
  parameter logic [(1<<ADDR_W)-1:0]  DEF_MASK    = '1,
  parameter logic [(1<<ADDR_W)-1:0]  WR_MASK     = '1,
  parameter int                      GRP_A       = 2,
  parameter int                      GRP_B       = 6,
  parameter int                      SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic [1:0]        rd_mode,
  output logic [ADDR_W-1:0] reg_raddr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata
);
  import spi_regmap_pkg::*;

  localparam int CTRL_W = DEV_W + ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W);

  logic              sck_rise, sck_fall, cs_idle, sdi_s;
  phase_e            phase;
  logic [DATA_W-1:0] rx, tx, rd_word, word_in;
  logic [CTRL_W-1:0] ctrl_in;
  logic [CNT_W-1:0]  bit_cnt, tx_cnt;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic              zero_all;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .sdi_s(sdi_s)
  );

  spi_rd_stepper #(.ADDR_W(ADDR_W), .GRP_A(GRP_A), .GRP_B(GRP_B)) u_step (
    .cur(cur_addr), .mode(rd_mode), .nxt(nxt_addr)
  );

  assign ctrl_in   = {rx[CTRL_W-2:0], sdi_s};
  assign word_in   = {rx[DATA_W-2:0], sdi_s};
  assign rd_word   = (zero_all || !DEF_MASK[cur_addr]) ? '0 : reg_rdata;
  assign reg_raddr = cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      rx        <= '0;
      tx        <= '0;
      bit_cnt   <= '0;
      tx_cnt    <= '0;
      cur_addr  <= '0;
      zero_all  <= 1'b0;
      sdo_o     <= 1'b0;
      sdo_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (cs_idle) begin
        phase  <= PH_IDLE;
        sdo_oe <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            phase   <= PH_CTRL;
            bit_cnt <= '0;
            rx      <= '0;
          end
          PH_CTRL: if (sck_rise) begin
            rx      <= word_in;
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == CNT_W'(CTRL_W - 1)) begin
              bit_cnt  <= '0;
              tx_cnt   <= '0;
              cur_addr <= ctrl_in[ADDR_W:1];
              zero_all <= !DEF_MASK[ctrl_in[ADDR_W:1]];
              if (ctrl_in[CTRL_W-1 -: DEV_W] != DEV_ID) phase <= PH_SKIP;
              else if (ctrl_in[0] == DIR_READ)          phase <= PH_READ;
              else                                      phase <= PH_WRITE;
            end
          end
          PH_READ: if (sck_fall) begin
            sdo_oe <= 1'b1;
            if (tx_cnt == '0) begin
              sdo_o    <= rd_word[DATA_W-1];
              tx       <= rd_word << 1;
              tx_cnt   <= CNT_W'(DATA_W - 1);
              cur_addr <= nxt_addr;
            end else begin
              sdo_o  <= tx[DATA_W-1];
              tx     <= tx << 1;
              tx_cnt <= tx_cnt - CNT_W'(1);
            end
          end
          PH_WRITE: if (sck_rise) begin
            rx      <= word_in;
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == CNT_W'(DATA_W - 1)) begin
              bit_cnt <= '0;
              if (DEF_MASK[cur_addr]) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                if (WR_MASK[cur_addr]) begin
                  reg_we    <= 1'b1;
                  reg_waddr <= cur_addr;
                  reg_wdata <= word_in;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: deselection releases the output on the next cycle
  assert_z_deselected_R3: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !sdo_oe);

  // R10 and R5: no drive while decoding, writing or skipping
  assert_no_drive_write_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE || phase == PH_CTRL || phase == PH_SKIP) |-> !sdo_oe);

  // R8: commits only land on defined, writable addresses
  assert_we_legal_R8: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (DEF_MASK[reg_waddr] && WR_MASK[reg_waddr]));

  // R8: one strobe per word
  assert_we_single_R8: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R9: undefined write address never advances
  assert_undef_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE && !cs_idle && !DEF_MASK[cur_addr]) |=> $stable(cur_addr));

  // R6: pair mode stays inside the aligned pair
  assert_pair_group_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && rd_mode == RM_PAIR) |-> nxt_addr[ADDR_W-1:1] == cur_addr[ADDR_W-1:1]);

  // R6: hold mode keeps the address
  assert_hold_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && rd_mode == RM_HOLD) |-> nxt_addr == cur_addr);
endmodule

// File: tb/spi_regmap_slave_bench.sv
`timescale 1ns/1ps
module spi_regmap_slave_bench;
  localparam logic [31:0] DEF = 32'hBFFF_EFFF;
  localparam logic [31:0] WRM = 32'h8000_FF01;
  localparam int HALF = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [1:0] rd_mode = 2'b11;
  logic sdo_o, sdo_oe, reg_we;
  logic [4:0] reg_raddr, reg_waddr;
  logic [23:0] reg_rdata, reg_wdata;

  logic [23:0] mem [32];
  logic [23:0] exp_r [32];
  logic [23:0] wbuf [4];
  logic [23:0] rbuf [4];
  int we_cnt = 0, n_chk = 0, n_fail = 0;
  bit ctrl_drv, data_drv, data_undrv;

  always #2 clk = ~clk;

  spi_regmap_slave #(.DEF_MASK(DEF), .WR_MASK(WRM)) u_spi_regmap_slave (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .rd_mode(rd_mode),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
  );

  always @(posedge clk) begin
    reg_rdata <= mem[reg_raddr];
    if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [23:0] init_val(input int i);
    return {8'hA5, 3'b0, 5'(i), 8'h3C ^ 8'(i)};
  endfunction

  function automatic logic [23:0] ev(input int a);
    if (a < 0 || !DEF[a]) return 24'h0;
    return exp_r[a];
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bit_io(input logic b, output logic got, output logic oe);
    sck = 1'b0; sdi = b;
    #(HALF);
    got = sdo_o; oe = sdo_oe;
    sck = 1'b1;
    #(HALF);
  endtask

  task automatic xfer(input bit idle_hi, input logic [7:0] ctrl, input int nw);
    logic g, o;
    ctrl_drv = 0; data_drv = 0; data_undrv = 0;
    sck = idle_hi; cs_n = 1'b0;
    #(HALF);
    for (int i = 7; i >= 0; i--) begin
      bit_io(ctrl[i], g, o);
      if (o) ctrl_drv = 1;
    end
    for (int w = 0; w < nw; w++)
      for (int b = 23; b >= 0; b--) begin
        bit_io(wbuf[w][b], g, o);
        rbuf[w][b] = g;
        if (o) data_drv = 1; else data_undrv = 1;
      end
    if (!idle_hi) begin sck = 1'b0; #(HALF); end
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  function automatic logic [7:0] cb(input logic [1:0] dev, input int a, input logic rd);
    return {dev, 5'(a), rd};
  endfunction

  // read frame with expected address list (-1 = zero word)
  task automatic rd_test(input string req, input bit idle_hi, input logic [1:0] m,
                         input int start, input int nw,
                         input int e0, input int e1, input int e2, input int e3);
    int ea [4];
    ea[0] = e0; ea[1] = e1; ea[2] = e2; ea[3] = e3;
    rd_mode = m;
    xfer(idle_hi, cb(2'b01, start, 1'b1), nw);
    chk({req, " R10 control byte undriven"}, 24'(ctrl_drv), 24'h0);
    chk({req, " R1 data phase driven"}, 24'(data_drv && !data_undrv), 24'h1);
    for (int w = 0; w < nw; w++) chk(req, rbuf[w], ev(ea[w]));
  endtask

  task automatic wr_frame(input int start, input int nw);
    xfer(1'b0, cb(2'b01, start, 1'b0), nw);
    chk("R10 write frame undriven", 24'(ctrl_drv || data_drv), 24'h0);
  endtask

  task automatic t_reset;
    chk("R11 sdo_oe after reset", 24'(sdo_oe), 24'h0);
    chk("R11 reg_we after reset", 24'(reg_we), 24'h0);
  endtask

  task automatic t_reads;
    rd_test("R6 R4 walk mode 11", 1'b0, 2'b11, 3, 3, 3, 4, 5, -1);
    rd_test("R6 R1 pair mode idle-high", 1'b1, 2'b01, 7, 3, 7, 6, 7, -1);
    rd_test("R6 six-block from 4", 1'b0, 2'b10, 4, 4, 4, 5, 0, 1);
    rd_test("R6 six-block from 28", 1'b1, 2'b10, 28, 3, 28, 29, 24, -1);
    rd_test("R6 hold mode", 1'b0, 2'b00, 9, 2, 9, 9, -1, -1);
    rd_test("R6 wrap 31 to 0", 1'b1, 2'b11, 31, 2, 31, 0, -1, -1);
    rd_test("R7 undefined start all zero", 1'b0, 2'b11, 12, 3, -1, -1, -1, -1);
    rd_test("R7 undefined mid-read zero", 1'b0, 2'b10, 31, 2, 31, 30, -1, -1);
  endtask

  task automatic t_write_linear;
    int c0;
    c0 = we_cnt;
    wbuf[0] = 24'h123456; wbuf[1] = 24'hFEDCBA;
    wr_frame(8, 2);
    exp_r[8] = 24'h123456; exp_r[9] = 24'hFEDCBA;
    chk("R8 two commits", 24'(we_cnt - c0), 24'd2);
    rd_test("R8 readback 8..9", 1'b0, 2'b11, 8, 2, 8, 9, -1, -1);
  endtask

  task automatic t_write_wrap;
    wbuf[0] = 24'h0F0F0F; wbuf[1] = 24'hA0B0C0;
    wr_frame(31, 2);
    exp_r[31] = 24'h0F0F0F; exp_r[0] = 24'hA0B0C0;
    rd_test("R8 wrap readback 31,0", 1'b1, 2'b11, 31, 2, 31, 0, -1, -1);
  endtask

  task automatic t_write_readonly;
    int c0;
    c0 = we_cnt;
    wbuf[0] = 24'h777777; wbuf[1] = 24'h888888; wbuf[2] = 24'h999999;
    wr_frame(15, 3);
    exp_r[15] = 24'h777777;
    chk("R8 read-only words discarded", 24'(we_cnt - c0), 24'd1);
    rd_test("R8 readback 15..17", 1'b0, 2'b11, 15, 3, 15, 16, 17, -1);
  endtask

  task automatic t_write_undef;
    int c0;
    c0 = we_cnt;
    wbuf[0] = 24'h111111; wbuf[1] = 24'h222222; wbuf[2] = 24'h333333;
    wr_frame(12, 3);
    chk("R9 no commit on undefined", 24'(we_cnt - c0), 24'd0);
    rd_test("R9 address 13 untouched", 1'b0, 2'b11, 13, 2, 13, 14, -1, -1);
  endtask

  task automatic t_mismatch;
    int c0;
    c0 = we_cnt;
    rd_mode = 2'b11;
    xfer(1'b0, cb(2'b10, 3, 1'b1), 2);
    chk("R5 mismatch read undriven", 24'(ctrl_drv || data_drv), 24'h0);
    wbuf[0] = 24'hDEAD00; wbuf[1] = 24'hBEEF00;
    xfer(1'b1, cb(2'b00, 8, 1'b0), 2);
    chk("R5 mismatch write no commit", 24'(we_cnt - c0), 24'd0);
    rd_test("R5 address 8 unchanged", 1'b0, 2'b11, 8, 1, 8, -1, -1, -1);
  endtask

  task automatic t_cs_high;
    int c0;
    bit drv;
    c0 = we_cnt; drv = 0;
    cs_n = 1'b1;
    for (int i = 0; i < 80; i++) begin
      sck = ~sck; sdi = i[1];
      #(HALF/2);
      if (sdo_oe) drv = 1;
    end
    sck = 1'b0;
    #(4*HALF);
    chk("R3 no drive while deselected", 24'(drv), 24'h0);
    chk("R3 no commit while deselected", 24'(we_cnt - c0), 24'd0);
  endtask

  task automatic t_abort;
    logic g, o;
    sck = 1'b0; cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < 5; i++) bit_io(1'b1, g, o);
    sck = 1'b0;
    #(HALF);
    cs_n = 1'b1;
    #(4*HALF);
    rd_test("R2 fresh frame after abort", 1'b0, 2'b11, 3, 1, 3, -1, -1, -1);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = init_val(i);
      exp_r[i] = init_val(i);
    end
    for (int i = 0; i < 4; i++) wbuf[i] = 24'h0;
    #1;
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_reads();
    t_write_linear();
    t_write_wrap();
    t_write_readonly();
    t_write_undef();
    t_mismatch();
    t_cs_high();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule